// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits under a direct-mapped cache, next to its refill path. Each time the cache misses it offers the missing line address to the buffer. The buffer keeps a short queue of lines that it fetched ahead of demand. Only the oldest entry in that queue is compared with the probe. If that entry matches and its data has arrived, the buffer hands the line to the cache in the same cycle and takes the entry out of the queue. It then fetches the next sequential line into the slot that has just become free.

A probe that does not match the oldest entry empties the queue and starts a new stream at the line after the probed one. This holds even when the probed line is further down the queue. Prefetched lines never go into the cache array until a probe claims them.

The next-level memory is pipelined and accepts new requests at its own pace, so several fetches can be in flight at the same time. Responses come back in request order. Each request carries a stream generation number, so responses that belong to a stream which was abandoned can be recognised and dropped. A stream never fetches past the end of the aligned page that holds the line that started it.

Top module: `seq_stream_buf`

## Requirements
- R1: After reset the queue is empty, `probe_ready` is high, `fill_hit` is low and no memory request is presented.
- R2: A probe accepted while the queue is empty, or while the oldest entry holds a different line, is a miss: `fill_hit` stays low in that cycle, every entry is dropped, and the next request is for probe line + 1.
- R3: Successive accepted memory requests of one stream are for consecutive line addresses. Each accepted request claims the youngest free entry, with that entry's data marked not yet present.
- R4: The queue never holds more than DEPTH entries. Once an idle stream holds DEPTH entries, no further request is made until an entry leaves the queue.
- R5: A probe that equals the oldest entry's line, with that entry's data present, raises `fill_hit` in the same cycle with `fill_data` equal to that line. The entry is removed, and a request for the next line of the stream follows into the freed slot.
- R6: A probe for the oldest entry whose data has not arrived, or for the very next line of an empty but live stream, holds `probe_ready` low until the data is present. The probe then completes as a hit.
- R7: A probe for a line that is queued at any position other than the oldest is handled as a miss, as in R2.
- R8: A stream stops after it requests the last line of its page of 2^PAGE_BITS lines. No request is ever made for a line whose low PAGE_BITS address bits are all zero.
- R9: Requests go out whenever the queue has room and the memory accepts them, so two or more requests can be outstanding together.
- R10: Every request carries the current generation number, and that number changes on each miss. A response whose generation differs from the current one is ignored.
- R11: Responses of the current generation fill pending entries in request order, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_valid | input | 1 | Cache presents a missing line address |
| probe_line | input | AW | Line address of the cache miss |
| probe_ready | output | 1 | Probe accepted this cycle (low while waiting for head data) |
| fill_hit | output | 1 | Accepted probe is supplied from the buffer |
| fill_data | output | DW | Line data of the oldest entry |
| mem_req_valid | output | 1 | Prefetch request presented to memory |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_line | output | AW | Line address of the prefetch request |
| mem_req_gen | output | GEN_W | Stream generation of the request |
| mem_rsp_valid | input | 1 | Memory returns a line |
| mem_rsp_gen | input | GEN_W | Generation echoed with the response |
| mem_rsp_data | input | DW | Returned line data |

## Verification
The bench builds the buffer with a depth of 4, 12-bit line addresses, 24-bit lines, pages of 16 lines and a 3-bit generation number. Its memory model accepts one request every 4 cycles and answers after 12 cycles. With pages that small, a stream that starts three lines before a page end reaches the stop condition in a few cycles. The slow memory keeps several requests in flight, which makes the empty-but-live stall and the dropping of stale responses after a quick run of misses easy to reach. Returned data encodes its own address, so any response that lands in the wrong entry shows up as a data mismatch.

// File: rtl/seq_stream_buf.sv
module seq_stream_buf #(
  parameter int DEPTH     = 4,
  parameter int AW        = 26,
  parameter int DW        = 64,
  parameter int PAGE_BITS = 6,
  parameter int GEN_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             probe_valid,
  input  logic [AW-1:0]    probe_line,
  output logic             probe_ready,
  output logic             fill_hit,
  output logic [DW-1:0]    fill_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_line,
  output logic [GEN_W-1:0] mem_req_gen,
  input  logic             mem_rsp_valid,
  input  logic [GEN_W-1:0] mem_rsp_gen,
  input  logic [DW-1:0]    mem_rsp_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DEPTH-1:0] avl_q;
  logic [PW-1:0]    hp, tp, rp;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    nxt_line;
  logic             more;
  logic [GEN_W-1:0] gen;

  logic head_match, wait_head, wait_next, take, flush, issue, rsp_ok;

  assign head_match = (cnt != '0) && (tag_q[hp] == probe_line);
  assign wait_head  = head_match && !avl_q[hp];
  assign wait_next  = (cnt == '0) && more && (nxt_line == probe_line);
  assign probe_ready = !(wait_head || wait_next);
  assign take       = probe_valid && probe_ready;
  assign fill_hit   = take && head_match;
  assign flush      = take && !head_match;
  assign fill_data  = dat_q[hp];

  assign mem_req_valid = more && (cnt != CW'(DEPTH)) && !flush;
  assign mem_req_line  = nxt_line;
  assign mem_req_gen   = gen;
  assign issue         = mem_req_valid && mem_req_ready;
  assign rsp_ok        = mem_rsp_valid && (mem_rsp_gen == gen) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp       <= '0;
      tp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      nxt_line <= '0;
      more     <= 1'b0;
      gen      <= '0;
      avl_q    <= '0;
    end else if (flush) begin
      hp       <= '0;
      tp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      gen      <= gen + 1'b1;
      nxt_line <= probe_line + 1'b1;
      more     <= !(&probe_line[PAGE_BITS-1:0]);
      avl_q    <= '0;
    end else begin
      if (issue) begin
        avl_q[tp] <= 1'b0;
        tp        <= step(tp);
        nxt_line  <= nxt_line + 1'b1;
        more      <= !(&nxt_line[PAGE_BITS-1:0]);
      end
      if (rsp_ok) begin
        avl_q[rp] <= 1'b1;
        rp        <= step(rp);
      end
      if (fill_hit) hp <= step(hp);
      cnt <= cnt + CW'(issue) - CW'(fill_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (issue) tag_q[tp] <= nxt_line;
    if (rsp_ok) dat_q[rp] <= mem_rsp_data;
  end
endmodule

// File: rtl/seq_stream_buf_chk.sv
module seq_stream_buf_chk #(
  parameter int DEPTH     = 4,
  parameter int AW        = 26,
  parameter int PAGE_BITS = 6,
  parameter int GEN_W     = 4,
  parameter int CW        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             probe_valid,
  input logic             probe_ready,
  input logic             fill_hit,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_line,
  input logic [GEN_W-1:0] mem_req_gen,
  input logic [CW-1:0]    cnt
);
  logic miss_take, req_fire;
  assign miss_take = probe_valid && probe_ready && !fill_hit;
  assign req_fire  = mem_req_valid && mem_req_ready;

  assert_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_page_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_line[PAGE_BITS-1:0] != '0));

  assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_take |=> (cnt == '0));

  assert_pop_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_hit && !req_fire) |=> (cnt == $past(cnt) - 1'b1));

  assert_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (!mem_req_valid || (mem_req_line == $past(mem_req_line) + 1'b1)));

  assert_new_gen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_take |=> (mem_req_gen != $past(mem_req_gen)));
endmodule

bind seq_stream_buf seq_stream_buf_chk #(
  .DEPTH(DEPTH), .AW(AW), .PAGE_BITS(PAGE_BITS), .GEN_W(GEN_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_ready(probe_ready),
  .fill_hit(fill_hit), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_line(mem_req_line), .mem_req_gen(mem_req_gen), .cnt(cnt)
);

// File: tb/seq_stream_buf_bench.sv
`timescale 1ns/1ps
module seq_stream_buf_bench;
  localparam int DEPTH = 4, AW = 12, DW = 24, PB = 4, GW = 3, LAT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          probe_valid = 1'b0;
  logic [AW-1:0] probe_line = '0;
  logic          probe_ready, fill_hit;
  logic [DW-1:0] fill_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_line;
  logic [GW-1:0] mem_req_gen;
  logic          mem_rsp_valid = 1'b0;
  logic [GW-1:0] mem_rsp_gen = '0;
  logic [DW-1:0] mem_rsp_data = '0;

  seq_stream_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PAGE_BITS(PB), .GEN_W(GW)) u_seq_stream_buf (
    .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_line(probe_line),
    .probe_ready(probe_ready), .fill_hit(fill_hit), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_req_gen(mem_req_gen),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_gen(mem_rsp_gen), .mem_rsp_data(mem_rsp_data)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard of expected probe outcomes
  bit            eq_hit[$];
  logic [AW-1:0] eq_line[$];
  bit            fired = 0;

  always @(negedge clk) begin
    if (rst_n && probe_valid && probe_ready) begin
      fired = 1;
      if (eq_hit.size() == 0) chk(0, "R2 unexpected accept", 1, 0);
      else begin
        bit h; logic [AW-1:0] a;
        h = eq_hit.pop_front(); a = eq_line.pop_front();
        chk(fill_hit == h, h ? "R5 hit flag" : "R2 miss flag", fill_hit, h);
        if (h) chk(fill_data == line_of(a), "R5 R11 fill data", fill_data, line_of(a));
      end
    end
  end

  // memory model: one request per 4 cycles, fixed latency, in order
  logic [AW-1:0] q_line[$];
  logic [GW-1:0] q_gen[$];
  int            q_due[$];
  int            cool = 0, max_inflight = 0, reqs_since = 0;
  logic [AW-1:0] exp_req = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        chk(mem_req_line == exp_req, "R3 request line", mem_req_line, exp_req);
        chk(mem_req_line[PB-1:0] != '0, "R8 page crossing", mem_req_line, exp_req);
        exp_req = exp_req + 1'b1;
        reqs_since++;
        q_line.push_back(mem_req_line);
        q_gen.push_back(mem_req_gen);
        q_due.push_back(cyc + LAT);
        cool = 3;
      end else if (cool > 0) cool--;
      mem_req_ready = (cool == 0);
      if (q_line.size() > max_inflight) max_inflight = q_line.size();
      if (q_due.size() > 0 && q_due[0] <= cyc) begin
        logic [AW-1:0] a;
        a = q_line.pop_front();
        mem_rsp_gen   = q_gen.pop_front();
        void'(q_due.pop_front());
        mem_rsp_data  = line_of(a);
        mem_rsp_valid = 1'b1;
      end else mem_rsp_valid = 1'b0;
    end
  end

  // reference stream state
  logic [AW-1:0] m_head = '0;
  bit            m_live = 0;

  task automatic probe(input logic [AW-1:0] a, output int waits);
    bit h;
    h = m_live && (a == m_head);
    eq_hit.push_back(h);
    eq_line.push_back(a);
    @(posedge clk); #1;
    probe_valid = 1'b1; probe_line = a; fired = 0; waits = 0;
    forever begin
      @(posedge clk);
      if (fired) break;
      waits++;
      if (waits > 500) break;
    end
    #1 probe_valid = 1'b0;
    if (h) begin
      m_head = m_head + 1'b1;
      m_live = (m_head[PB-1:0] != '0);
    end else begin
      m_head = a + 1'b1;
      m_live = (a[PB-1:0] != '1);
      exp_req = a + 1'b1;
      reqs_since = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(probe_ready == 1'b1, "R1 ready after reset", probe_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 no request after reset", mem_req_valid, 0);
    chk(fill_hit == 1'b0, "R1 no hit after reset", fill_hit, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2/R4: start a stream and let it fill
    probe(12'h040, w);
    idle(80);
    chk(reqs_since == DEPTH, "R4 fill to depth", reqs_since, DEPTH);
    // R5: head hit in one cycle, freed slot refilled
    probe(12'h041, w);
    chk(w == 0, "R5 no wait on ready head", w, 0);
    idle(20);
    chk(reqs_since == DEPTH + 1, "R5 refill after pop", reqs_since, DEPTH + 1);
    // R7: deeper line is a miss
    probe(12'h044, w);
    idle(80);
    probe(12'h045, w);
    probe(12'h046, w);

    // R6: probe the next line right after a miss
    probe(12'h080, w);
    probe(12'h081, w);
    chk(w > 0, "R6 stall until data", w, 1);
    probe(12'h082, w);
    probe(12'h083, w);

    // R8: page end stops the stream
    probe(12'h01C, w);
    idle(80);
    chk(reqs_since == 3, "R8 stop at page end", reqs_since, 3);
    probe(12'h01D, w);
    probe(12'h01E, w);
    probe(12'h01F, w);
    idle(20);
    chk(reqs_since == 3, "R8 no request past page", reqs_since, 3);
    probe(12'h020, w);

    // R10: quick run of misses leaves stale responses in flight
    probe(12'h100, w);
    probe(12'h205, w);
    probe(12'h30A, w);
    probe(12'h407, w);
    probe(12'h408, w);
    probe(12'h409, w);
    probe(12'h40A, w);
    idle(40);
    chk(eq_hit.size() == 0, "R10 scoreboard drained", eq_hit.size(), 0);
    chk(max_inflight >= 2, "R9 overlapped requests", max_inflight, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule